// File: doc/BRIEF.md
# Multicycle Control Sequencer with Exception Entry

This block is the hardwired control sequencer for a small multicycle processor. Each instruction is split into several clock cycles: fetch, decode/register read, then a short opcode-dependent tail for memory access, register-to-register arithmetic, conditional branch or unconditional jump. In every cycle the sequencer drives the datapath selects and write enables. The ALU, memory and register file sit outside the block.

Two faults are handled precisely. The first is an opcode that matches no known class. The second is an arithmetic overflow flagged during a register-to-register execute cycle. In both cases the sequencer spends one cycle recording a cause code in its cause register. It then spends one vector cycle in which the ALU is set up to form PC minus 4, that value is captured into the exception PC register, and the PC is loaded from the handler-address mux input. The faulting instruction never writes a register. Both exception registers can be read at any time on output ports.

The control word is held in flops and loaded from the decode of the next state. The outputs therefore change only at clock edges and always match the current state.

Top module: `mc_exc_sequencer`

## Requirements
- R1: While `rst` is high at a clock edge, the sequencer enters fetch, and `epc` and `cause` become zero. The first cycle after reset shows the fetch control word.
- R2: In fetch, these outputs are 1: `mem_read`, `ir_write` and `pc_write`. These selects are 0: `iord`, `alu_src_a` and `pc_source`. `alu_src_b`=01 (constant 4) and `alu_op`=00 (add). Every control not named for a cycle is 0 in that cycle. Fetch is always followed by decode, where `alu_src_b`=11, `alu_op`=00 and all other controls are 0.
- R3: Opcodes are 6 bits. Load is 0x23 and store is 0x2B. For either, decode is followed by an address cycle: `alu_src_a`=1, `alu_src_b`=10, `alu_op`=00. A load then runs a read cycle (`mem_read`, `iord`=1), then a write-back cycle (`reg_write`, `mem_to_reg`=1, `reg_dst`=0). A store runs one write cycle (`mem_write`, `iord`=1). Both then return to fetch.
- R4: Opcode 0x00 (register type) runs an execute cycle: `alu_src_a`=1, `alu_src_b`=00, `alu_op`=10. If `alu_ovf` is low at the end of that cycle, a write-back cycle follows (`reg_write`, `reg_dst`=1, `mem_to_reg`=0), then fetch.
- R5: Opcode 0x04 (branch-if-equal) runs one cycle with `pc_write_cond`=1, `alu_src_a`=1, `alu_src_b`=00, `alu_op`=01 and `pc_source`=01. Opcode 0x02 (jump) runs one cycle with `pc_write`=1 and `pc_source`=10. Both then return to fetch.
- R6: Any other opcode at the end of decode leads to one cause cycle: `cause_write`=1, `int_cause`=0. After it, `cause` reads 0.
- R7: If `alu_ovf` is high at the end of the execute cycle, the write-back cycle is skipped and `reg_write` is never asserted for that instruction. Instead, one cause cycle follows with `cause_write`=1 and `int_cause`=1. After it, `cause` reads 1.
- R8: Every cause cycle is followed by one vector cycle and then fetch. The vector cycle has `alu_src_a`=0, `alu_src_b`=01, `alu_op`=01, `epc_write`=1, `pc_write`=1 and `pc_source`=11. At the end of the vector cycle, `epc` takes the value of `alu_result`.
- R9: `epc` and `cause` change only at the ends of vector and cause cycles respectively. Changes on `alu_result` at any other time have no effect on them.
- R10: `alu_ovf` is ignored outside the execute cycle. With the flag held high, a load runs its normal sequence and leaves `cause` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| opcode | input | OP_W | Opcode field of the instruction register |
| alu_ovf | input | 1 | ALU signed-overflow flag |
| alu_result | input | DATA_W | ALU output, captured into EPC in the vector cycle |
| mem_read | output | 1 | Memory read enable |
| mem_write | output | 1 | Memory write enable |
| ir_write | output | 1 | Instruction register load |
| pc_write | output | 1 | Unconditional PC load |
| pc_write_cond | output | 1 | PC load when the ALU reports equal |
| iord | output | 1 | Memory address select: 0 = PC, 1 = ALUOut |
| reg_dst | output | 1 | Destination register select: 1 = rd field |
| mem_to_reg | output | 1 | Write-back data select: 1 = memory data |
| reg_write | output | 1 | Register file write enable |
| alu_src_a | output | 1 | ALU A select: 0 = PC, 1 = register A |
| alu_src_b | output | 2 | ALU B select: 00 reg B, 01 four, 10 immediate, 11 shifted immediate |
| alu_op | output | 2 | ALU operation class: 00 add, 01 subtract, 10 function field |
| pc_source | output | 2 | PC mux: 00 ALU result, 01 ALUOut, 10 jump target, 11 handler address |
| epc_write | output | 1 | EPC write enable (vector cycle) |
| cause_write | output | 1 | Cause write enable |
| int_cause | output | 1 | Cause code: 0 undefined opcode, 1 overflow |
| epc | output | DATA_W | Exception PC register |
| cause | output | CAUSE_W | Cause register |

## Verification
Each opcode class is driven through a full instruction, and the control word is compared in every cycle. This shows that dispatch from decode picks the right tail and returns to fetch. A register-type instruction is run twice, once with the overflow flag low and once with it high at the end of execute. These two runs separate normal write-back from the cause-and-vector path, and confirm that no register write slips out. An unknown opcode after the overflow run moves the cause register from 1 back to 0. A load with the overflow flag held high shows the flag is ignored outside execute. Changes on the ALU result outside the vector cycle show that the exception registers hold their values.

// File: rtl/mcc_pkg.sv
package mcc_pkg;

  typedef enum logic [3:0] {
    S_FETCH  = 4'd0,
    S_DECODE = 4'd1,
    S_MADDR  = 4'd2,
    S_MRD    = 4'd3,
    S_MWB    = 4'd4,
    S_MWR    = 4'd5,
    S_REXE   = 4'd6,
    S_RWB    = 4'd7,
    S_BR     = 4'd8,
    S_JMP    = 4'd9,
    S_ILL    = 4'd10,
    S_OVF    = 4'd11,
    S_VEC    = 4'd12
  } state_e;

  localparam logic [1:0] SRCB_REG  = 2'b00;
  localparam logic [1:0] SRCB_FOUR = 2'b01;
  localparam logic [1:0] SRCB_IMM  = 2'b10;
  localparam logic [1:0] SRCB_BOFS = 2'b11;

  localparam logic [1:0] AOP_ADD  = 2'b00;
  localparam logic [1:0] AOP_SUB  = 2'b01;
  localparam logic [1:0] AOP_FUNC = 2'b10;

  localparam logic [1:0] PCS_ALU    = 2'b00;
  localparam logic [1:0] PCS_ALUOUT = 2'b01;
  localparam logic [1:0] PCS_JUMP   = 2'b10;
  localparam logic [1:0] PCS_VEC    = 2'b11;

  localparam logic CODE_UNDEF = 1'b0;
  localparam logic CODE_OVF   = 1'b1;

  typedef struct packed {
    logic       mem_read;
    logic       mem_write;
    logic       ir_write;
    logic       pc_write;
    logic       pc_write_cond;
    logic       iord;
    logic       reg_dst;
    logic       mem_to_reg;
    logic       reg_write;
    logic       alu_src_a;
    logic [1:0] alu_src_b;
    logic [1:0] alu_op;
    logic [1:0] pc_source;
    logic       epc_write;
    logic       cause_write;
    logic       int_cause;
  } ctrl_t;

endpackage

// File: rtl/mcc_next_state.sv
module mcc_next_state
  import mcc_pkg::*;
#(
  parameter int            OP_W   = 6,
  parameter logic [OP_W-1:0] OP_RTYPE = 6'h00,
  parameter logic [OP_W-1:0] OP_LOAD  = 6'h23,
  parameter logic [OP_W-1:0] OP_STORE = 6'h2B,
  parameter logic [OP_W-1:0] OP_BEQ   = 6'h04,
  parameter logic [OP_W-1:0] OP_JUMP  = 6'h02
) (
  input  state_e          cur,
  input  logic [OP_W-1:0] opcode,
  input  logic            alu_ovf,
  output state_e          nxt
);

  always_comb begin
    nxt = S_FETCH;
    unique case (cur)
      S_FETCH:  nxt = S_DECODE;
      S_DECODE: begin
        if (opcode == OP_LOAD || opcode == OP_STORE) nxt = S_MADDR;
        else if (opcode == OP_RTYPE)                 nxt = S_REXE;
        else if (opcode == OP_BEQ)                   nxt = S_BR;
        else if (opcode == OP_JUMP)                  nxt = S_JMP;
        else                                         nxt = S_ILL;
      end
      S_MADDR:  nxt = (opcode == OP_LOAD) ? S_MRD : S_MWR;
      S_MRD:    nxt = S_MWB;
      S_REXE:   nxt = alu_ovf ? S_OVF : S_RWB;
      S_ILL,
      S_OVF:    nxt = S_VEC;
      default:  nxt = S_FETCH;
    endcase
  end

endmodule

// File: rtl/mcc_ctrl_decode.sv
module mcc_ctrl_decode
  import mcc_pkg::*;
(
  input  state_e st,
  output ctrl_t  cw
);

  always_comb begin
    cw = '0;
    unique case (st)
      S_FETCH: begin
        cw.mem_read  = 1'b1;
        cw.ir_write  = 1'b1;
        cw.pc_write  = 1'b1;
        cw.alu_src_b = SRCB_FOUR;
        cw.alu_op    = AOP_ADD;
        cw.pc_source = PCS_ALU;
      end
      S_DECODE: begin
        cw.alu_src_b = SRCB_BOFS;
        cw.alu_op    = AOP_ADD;
      end
      S_MADDR: begin
        cw.alu_src_a = 1'b1;
        cw.alu_src_b = SRCB_IMM;
        cw.alu_op    = AOP_ADD;
      end
      S_MRD: begin
        cw.mem_read = 1'b1;
        cw.iord     = 1'b1;
      end
      S_MWB: begin
        cw.reg_write  = 1'b1;
        cw.mem_to_reg = 1'b1;
      end
      S_MWR: begin
        cw.mem_write = 1'b1;
        cw.iord      = 1'b1;
      end
      S_REXE: begin
        cw.alu_src_a = 1'b1;
        cw.alu_src_b = SRCB_REG;
        cw.alu_op    = AOP_FUNC;
      end
      S_RWB: begin
        cw.reg_write = 1'b1;
        cw.reg_dst   = 1'b1;
      end
      S_BR: begin
        cw.pc_write_cond = 1'b1;
        cw.alu_src_a     = 1'b1;
        cw.alu_src_b     = SRCB_REG;
        cw.alu_op        = AOP_SUB;
        cw.pc_source     = PCS_ALUOUT;
      end
      S_JMP: begin
        cw.pc_write  = 1'b1;
        cw.pc_source = PCS_JUMP;
      end
      S_ILL: begin
        cw.cause_write = 1'b1;
        cw.int_cause   = CODE_UNDEF;
      end
      S_OVF: begin
        cw.cause_write = 1'b1;
        cw.int_cause   = CODE_OVF;
      end
      S_VEC: begin
        cw.alu_src_b = SRCB_FOUR;
        cw.alu_op    = AOP_SUB;
        cw.epc_write = 1'b1;
        cw.pc_write  = 1'b1;
        cw.pc_source = PCS_VEC;
      end
      default: cw = '0;
    endcase
  end

endmodule

// File: rtl/mcc_exc_regs.sv
module mcc_exc_regs #(
  parameter int DATA_W  = 32,
  parameter int CAUSE_W = 32
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               epc_we,
  input  logic [DATA_W-1:0]  epc_d,
  input  logic               cause_we,
  input  logic               cause_code,
  output logic [DATA_W-1:0]  epc_q,
  output logic [CAUSE_W-1:0] cause_q
);

  localparam int CAUSE_PAD = CAUSE_W - 1;

  always_ff @(posedge clk) begin
    if (rst) begin
      epc_q <= '0;
    end else if (epc_we) begin
      epc_q <= epc_d;
    end
  end

  generate
    if (CAUSE_PAD > 0) begin : g_wide_cause
      always_ff @(posedge clk) begin
        if (rst) begin
          cause_q <= '0;
        end else if (cause_we) begin
          cause_q <= {{CAUSE_PAD{1'b0}}, cause_code};
        end
      end
    end else begin : g_bit_cause
      always_ff @(posedge clk) begin
        if (rst) begin
          cause_q <= '0;
        end else if (cause_we) begin
          cause_q <= cause_code;
        end
      end
    end
  endgenerate

endmodule

// File: rtl/mc_exc_sequencer.sv
module mc_exc_sequencer
  import mcc_pkg::*;
#(
  parameter int DATA_W  = 32,
  parameter int OP_W    = 6,
  parameter int CAUSE_W = 32,
  parameter logic [OP_W-1:0] OP_RTYPE = 6'h00,
  parameter logic [OP_W-1:0] OP_LOAD  = 6'h23,
  parameter logic [OP_W-1:0] OP_STORE = 6'h2B,
  parameter logic [OP_W-1:0] OP_BEQ   = 6'h04,
  parameter logic [OP_W-1:0] OP_JUMP  = 6'h02
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [OP_W-1:0]    opcode,
  input  logic               alu_ovf,
  input  logic [DATA_W-1:0]  alu_result,
  output logic               mem_read,
  output logic               mem_write,
  output logic               ir_write,
  output logic               pc_write,
  output logic               pc_write_cond,
  output logic               iord,
  output logic               reg_dst,
  output logic               mem_to_reg,
  output logic               reg_write,
  output logic               alu_src_a,
  output logic [1:0]         alu_src_b,
  output logic [1:0]         alu_op,
  output logic [1:0]         pc_source,
  output logic               epc_write,
  output logic               cause_write,
  output logic               int_cause,
  output logic [DATA_W-1:0]  epc,
  output logic [CAUSE_W-1:0] cause
);

  state_e state_q;
  state_e state_d;
  state_e state_sel;
  ctrl_t  cw_d;
  ctrl_t  cw_q;

  mcc_next_state #(
    .OP_W(OP_W), .OP_RTYPE(OP_RTYPE), .OP_LOAD(OP_LOAD),
    .OP_STORE(OP_STORE), .OP_BEQ(OP_BEQ), .OP_JUMP(OP_JUMP)
  ) i_next (
    .cur    (state_q),
    .opcode (opcode),
    .alu_ovf(alu_ovf),
    .nxt    (state_d)
  );

  // control word is decoded from the state about to be entered and registered
  assign state_sel = rst ? S_FETCH : state_d;

  mcc_ctrl_decode i_dec (
    .st(state_sel),
    .cw(cw_d)
  );

  always_ff @(posedge clk) begin
    state_q <= state_sel;
    cw_q    <= cw_d;
  end

  mcc_exc_regs #(.DATA_W(DATA_W), .CAUSE_W(CAUSE_W)) i_exc (
    .clk       (clk),
    .rst       (rst),
    .epc_we    (cw_q.epc_write),
    .epc_d     (alu_result),
    .cause_we  (cw_q.cause_write),
    .cause_code(cw_q.int_cause),
    .epc_q     (epc),
    .cause_q   (cause)
  );

  assign mem_read      = cw_q.mem_read;
  assign mem_write     = cw_q.mem_write;
  assign ir_write      = cw_q.ir_write;
  assign pc_write      = cw_q.pc_write;
  assign pc_write_cond = cw_q.pc_write_cond;
  assign iord          = cw_q.iord;
  assign reg_dst       = cw_q.reg_dst;
  assign mem_to_reg    = cw_q.mem_to_reg;
  assign reg_write     = cw_q.reg_write;
  assign alu_src_a     = cw_q.alu_src_a;
  assign alu_src_b     = cw_q.alu_src_b;
  assign alu_op        = cw_q.alu_op;
  assign pc_source     = cw_q.pc_source;
  assign epc_write     = cw_q.epc_write;
  assign cause_write   = cw_q.cause_write;
  assign int_cause     = cw_q.int_cause;

endmodule

// File: rtl/mc_exc_sequencer_chk.sv
module mc_exc_sequencer_chk #(
  parameter int DATA_W  = 32,
  parameter int OP_W    = 6,
  parameter int CAUSE_W = 32
) (
  input logic               clk,
  input logic               rst,
  input logic [OP_W-1:0]    opcode,
  input logic               alu_ovf,
  input logic [DATA_W-1:0]  alu_result,
  input logic               mem_read,
  input logic               mem_write,
  input logic               ir_write,
  input logic               pc_write,
  input logic               pc_write_cond,
  input logic               iord,
  input logic               reg_dst,
  input logic               mem_to_reg,
  input logic               reg_write,
  input logic               alu_src_a,
  input logic [1:0]         alu_src_b,
  input logic [1:0]         alu_op,
  input logic [1:0]         pc_source,
  input logic               epc_write,
  input logic               cause_write,
  input logic               int_cause,
  input logic [DATA_W-1:0]  epc,
  input logic [CAUSE_W-1:0] cause
);

  a_r1_reset_state: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (epc == '0 && cause == '0 && ir_write && mem_read && pc_write));

  a_r2_fetch_then_decode: assert property (@(posedge clk) disable iff (rst)
    ir_write |=> (alu_src_b == 2'b11 && !pc_write && !mem_read && !ir_write));

  a_r3_mem_exclusive: assert property (@(posedge clk) disable iff (rst)
    $onehot0({mem_read, mem_write}));

  a_r4_rtype_wb_select: assert property (@(posedge clk) disable iff (rst)
    (reg_write && reg_dst) |-> !mem_to_reg);

  a_r7_no_overflow: assert property (@(posedge clk) disable iff (rst)
    (alu_src_a && alu_op == 2'b10 && alu_ovf) |=> (!reg_write && cause_write && int_cause));

  a_r8_vector_follows: assert property (@(posedge clk) disable iff (rst)
    cause_write |=> (epc_write && pc_write && pc_source == 2'b11 && !cause_write));

  a_r8_epc_capture: assert property (@(posedge clk) disable iff (rst)
    epc_write |=> (epc == $past(alu_result)));

  a_r9_epc_hold: assert property (@(posedge clk) disable iff (rst)
    !epc_write |=> $stable(epc));

  a_r9_cause_hold: assert property (@(posedge clk) disable iff (rst)
    !cause_write |=> $stable(cause));

endmodule

bind mc_exc_sequencer mc_exc_sequencer_chk #(
  .DATA_W(DATA_W), .OP_W(OP_W), .CAUSE_W(CAUSE_W)
) i_chk (
  .clk(clk), .rst(rst), .opcode(opcode), .alu_ovf(alu_ovf), .alu_result(alu_result),
  .mem_read(mem_read), .mem_write(mem_write), .ir_write(ir_write), .pc_write(pc_write),
  .pc_write_cond(pc_write_cond), .iord(iord), .reg_dst(reg_dst), .mem_to_reg(mem_to_reg),
  .reg_write(reg_write), .alu_src_a(alu_src_a), .alu_src_b(alu_src_b), .alu_op(alu_op),
  .pc_source(pc_source), .epc_write(epc_write), .cause_write(cause_write),
  .int_cause(int_cause), .epc(epc), .cause(cause)
);

// File: tb/test_mc_exc_sequencer.sv
module test_mc_exc_sequencer;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [5:0]  opcode = 6'h00;
  logic        alu_ovf = 1'b0;
  logic [31:0] alu_result = 32'h0;
  logic        mem_read, mem_write, ir_write, pc_write, pc_write_cond, iord;
  logic        reg_dst, mem_to_reg, reg_write, alu_src_a;
  logic [1:0]  alu_src_b, alu_op, pc_source;
  logic        epc_write, cause_write, int_cause;
  logic [31:0] epc, cause;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  always #5 clk = ~clk;

  mc_exc_sequencer i_mc_exc_sequencer (
    .clk(clk), .rst(rst), .opcode(opcode), .alu_ovf(alu_ovf), .alu_result(alu_result),
    .mem_read(mem_read), .mem_write(mem_write), .ir_write(ir_write), .pc_write(pc_write),
    .pc_write_cond(pc_write_cond), .iord(iord), .reg_dst(reg_dst), .mem_to_reg(mem_to_reg),
    .reg_write(reg_write), .alu_src_a(alu_src_a), .alu_src_b(alu_src_b), .alu_op(alu_op),
    .pc_source(pc_source), .epc_write(epc_write), .cause_write(cause_write),
    .int_cause(int_cause), .epc(epc), .cause(cause)
  );

  // bench-side control word: mr mw irw pcw pcwc iord rd m2r rw sa sb aop ps epcw cw ic
  function automatic logic [18:0] cw(
    input logic mr, mw, irw, pcw, pcwc, io, rd, m2r, rw, sa,
    input logic [1:0] sb, aop, ps,
    input logic ew, caw, ic);
    return {mr, mw, irw, pcw, pcwc, io, rd, m2r, rw, sa, sb, aop, ps, ew, caw, ic};
  endfunction

  localparam logic [18:0] W_FETCH = {1'b1,1'b0,1'b1,1'b1,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,2'b01,2'b00,2'b00,1'b0,1'b0,1'b0};
  localparam logic [18:0] W_DEC   = {10'b0,2'b11,2'b00,2'b00,3'b0};
  localparam logic [18:0] W_MADDR = {9'b0,1'b1,2'b10,2'b00,2'b00,3'b0};
  localparam logic [18:0] W_MRD   = {1'b1,4'b0,1'b1,4'b0,6'b0,3'b0};
  localparam logic [18:0] W_MWB   = {7'b0,1'b1,1'b1,1'b0,6'b0,3'b0};
  localparam logic [18:0] W_MWR   = {1'b0,1'b1,3'b0,1'b1,4'b0,6'b0,3'b0};
  localparam logic [18:0] W_REXE  = {9'b0,1'b1,2'b00,2'b10,2'b00,3'b0};
  localparam logic [18:0] W_RWB   = {6'b0,1'b1,1'b0,1'b1,1'b0,6'b0,3'b0};
  localparam logic [18:0] W_BR    = {4'b0,1'b1,4'b0,1'b1,2'b00,2'b01,2'b01,3'b0};
  localparam logic [18:0] W_JMP   = {3'b0,1'b1,6'b0,2'b00,2'b00,2'b10,3'b0};
  localparam logic [18:0] W_ILL   = {16'b0,1'b0,1'b1,1'b0};
  localparam logic [18:0] W_OVF   = {16'b0,1'b0,1'b1,1'b1};
  localparam logic [18:0] W_VEC   = {3'b0,1'b1,6'b0,2'b01,2'b01,2'b11,1'b1,1'b0,1'b0};

  function automatic logic [18:0] outs();
    return {mem_read, mem_write, ir_write, pc_write, pc_write_cond, iord, reg_dst,
            mem_to_reg, reg_write, alu_src_a, alu_src_b, alu_op, pc_source,
            epc_write, cause_write, int_cause};
  endfunction

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic chk_cw(input logic [18:0] exp, input string req);
    n_chk++;
    if (outs() !== exp) begin
      n_fail++;
      $display("FAIL %s control actual=%b expected=%b", req, outs(), exp);
    end
  endtask

  task automatic chk_val(input logic [31:0] act, input logic [31:0] exp, input string req);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s value actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic t_r1_reset();
    rst = 1'b1;
    tick(); tick();
    rst = 1'b0;
    chk_cw(W_FETCH, "R1");
    chk_val(epc, 32'h0, "R1");
    chk_val(cause, 32'h0, "R1");
  endtask

  task automatic t_r3_load(input logic ovf, input string req);
    opcode = 6'h23; alu_ovf = ovf;
    chk_cw(W_FETCH, "R2"); tick();
    chk_cw(W_DEC, "R2");   tick();
    chk_cw(W_MADDR, req);  tick();
    chk_cw(W_MRD, req);    tick();
    chk_cw(W_MWB, req);    tick();
    chk_cw(W_FETCH, req);
    alu_ovf = 1'b0;
  endtask

  task automatic t_r3_store();
    opcode = 6'h2B;
    tick(); chk_cw(W_DEC, "R2");
    tick(); chk_cw(W_MADDR, "R3");
    tick(); chk_cw(W_MWR, "R3");
    tick(); chk_cw(W_FETCH, "R3");
  endtask

  task automatic t_r4_rtype();
    opcode = 6'h00; alu_ovf = 1'b0;
    tick(); chk_cw(W_DEC, "R2");
    tick(); chk_cw(W_REXE, "R4");
    tick(); chk_cw(W_RWB, "R4");
    tick(); chk_cw(W_FETCH, "R4");
  endtask

  task automatic t_r5_branch_jump();
    opcode = 6'h04;
    tick(); chk_cw(W_DEC, "R2");
    tick(); chk_cw(W_BR, "R5");
    tick(); chk_cw(W_FETCH, "R5");
    opcode = 6'h02;
    tick(); chk_cw(W_DEC, "R2");
    tick(); chk_cw(W_JMP, "R5");
    tick(); chk_cw(W_FETCH, "R5");
  endtask

  task automatic t_r7_overflow();
    opcode = 6'h00; alu_ovf = 1'b0;
    tick(); chk_cw(W_DEC, "R2");
    tick(); chk_cw(W_REXE, "R4");
    alu_ovf = 1'b1;
    tick(); chk_cw(W_OVF, "R7");
    alu_ovf = 1'b0;
    alu_result = 32'h0000_1FFC;
    tick(); chk_cw(W_VEC, "R8");
    chk_val(cause, 32'h1, "R7");
    alu_result = 32'h0000_0ABC;
    tick(); chk_cw(W_FETCH, "R8");
    chk_val(epc, 32'h0000_0ABC, "R8");
  endtask

  task automatic t_r6_illegal();
    opcode = 6'h3F;
    tick(); chk_cw(W_DEC, "R2");
    tick(); chk_cw(W_ILL, "R6");
    alu_result = 32'h0000_4440;
    tick(); chk_cw(W_VEC, "R8");
    chk_val(cause, 32'h0, "R6");
    tick(); chk_cw(W_FETCH, "R8");
    chk_val(epc, 32'h0000_4440, "R8");
  endtask

  task automatic t_r9_hold();
    opcode = 6'h00;
    for (int i = 0; i < 4; i++) begin
      alu_result = 32'hDEAD_0000 + 32'(i);
      tick();
    end
    chk_val(epc, 32'h0000_4440, "R9");
    chk_val(cause, 32'h0, "R9");
    chk_cw(W_FETCH, "R9");
  endtask

  initial begin
    t_r1_reset();
    t_r3_load(1'b0, "R3");
    t_r3_store();
    t_r4_rtype();
    t_r5_branch_jump();
    t_r7_overflow();
    t_r3_load(1'b1, "R10");
    chk_val(cause, 32'h1, "R10");
    t_r6_illegal();
    t_r9_hold();
    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL R1 watchdog actual=running expected=finished");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

endmodule